// File: doc/BRIEF.md
# Stereo Volume Change Sequencer

This block scales a stereo stream of 24-bit signed PCM samples by a per-channel attenuation setting. It also controls how a new setting reaches the audio, so that volume changes do not click. Each channel keeps its own current attenuation code and moves it toward the code on its target input. A 2-bit policy decides when that happens. A new code can take effect at once, at the channel's next zero crossing, through a gradual one-step-per-tick ramp, or through a ramp whose steps each wait for a zero crossing. When no zero crossing comes, a timeout forces the pending change through.

Samples arrive with a one-cycle valid strobe. All state advances only on strobes. The scaled and optionally polarity-inverted results appear on registered outputs one clock later. The attenuation code indexes a computed gain table that has eight fractional steps per octave. Each output is rounded and saturated back to 24 bits.

Top module: `vol_seq`

## Requirements
- R1: With strobe on `in_valid`, the next clock raises `out_valid` and presents, per channel, `sat24(floor((s*G + 32768) / 65536))`. Here `s` is the signed input sample. `G = round(65536 * 2^(-(c mod 8)/8)) >> (c div 8)`, where `c` is the 6-bit code in force for that strobe. `out_valid` is low one clock after a cycle without strobe.
- R2: Policy 00: the code in force for a strobe equals that strobe's target input.
- R3: Policy 01: the code jumps to the target only on a strobe that is a zero crossing (or timeout); otherwise it holds. A zero crossing is a sample equal to zero, or a sample whose sign bit differs from that of the channel's previous strobed sample. The previous sample is 0 after reset.
- R4: A per-channel counter of strobes is cleared by a strobe that changes the target input or the code. The timeout fires on the 1024th strobe after such a clearing strobe when the target is unchanged.
- R5: Policy 10: a ramp tick occurs on every 8th strobe counted from reset. On a tick the code moves one step toward the target, and it stops exactly at it.
- R6: Policy 11: a tick arms a step. The armed step is applied on the first strobe that is a zero crossing or timeout, including the tick strobe itself. The armed state is cleared when the step is taken or the code already equals the target.
- R7: The two channels detect crossings, count timeouts and update codes independently.
- R8: The policy input is captured with each strobe and governs strobes after it. After reset the policy is 11.
- R9: With `invert` high on a strobe, each output is the negation of the scaled value, and -8388608 saturates to 8388607.
- R10: Cycles without strobe change no state, whatever the other inputs do. After reset `out_valid`, `out_l` and `out_r` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_l | input | 24 | Left signed sample |
| in_r | input | 24 | Right signed sample |
| atten_l | input | 6 | Left target attenuation code |
| atten_r | input | 6 | Right target attenuation code |
| mode | input | 2 | Change policy: 00 immediate, 01 zero cross, 10 ramp, 11 ramp on zero cross |
| invert | input | 1 | Negate outputs |
| out_valid | output | 1 | Output strobe, one clock after `in_valid` |
| out_l | output | 24 | Left scaled sample |
| out_r | output | 24 | Right scaled sample |

## Verification
Every result of a strobe is due exactly one clock later, because the code update, gain lookup, multiply and inversion all feed the single output register. A policy value takes effect one strobe after it is presented. A ramp step lands on strobe multiples of 8. A timeout lands 1024 strobes after the clearing strobe, however many idle cycles lie between. The bench drives inputs on the falling edge, steps a behavioural model for each strobe, and on the next falling edge compares `out_valid` and both samples against the values the model predicted for the strobe one clock earlier.

// File: rtl/vol_seq_pkg.sv
package vol_seq_pkg;
  localparam int SW   = 24;  // sample width
  localparam int CW   = 6;   // attenuation code width
  localparam int GW   = 17;  // gain width, unity = 2**FRAC
  localparam int FRAC = 16;
  localparam int PW   = SW + GW + 1;

  localparam logic signed [SW-1:0] S_MAX = {1'b0, {(SW-1){1'b1}}};
  localparam logic signed [SW-1:0] S_MIN = {1'b1, {(SW-1){1'b0}}};

  typedef enum logic [1:0] {
    POL_NOW  = 2'b00,
    POL_ZC   = 2'b01,
    POL_RAMP = 2'b10,
    POL_BOTH = 2'b11
  } policy_e;

  // Eighth-octave mantissa, then shift by whole octaves.
  function automatic logic [GW-1:0] gain_of(input logic [CW-1:0] code);
    logic [GW-1:0] base;
    case (code[2:0])
      3'd0: base = 17'd65536;
      3'd1: base = 17'd60097;
      3'd2: base = 17'd55109;
      3'd3: base = 17'd50535;
      3'd4: base = 17'd46341;
      3'd5: base = 17'd42495;
      3'd6: base = 17'd38968;
      default: base = 17'd35734;
    endcase
    return base >> code[CW-1:3];
  endfunction

  function automatic logic signed [SW-1:0] scale_sat(input logic signed [SW-1:0] s,
                                                     input logic [GW-1:0] g);
    logic signed [PW-1:0] a, b, p, r;
    a = PW'(s);
    b = PW'({1'b0, g});
    p = a * b + (PW'(1) <<< (FRAC - 1));
    r = p >>> FRAC;
    if (r > PW'(S_MAX))      return S_MAX;
    else if (r < PW'(S_MIN)) return S_MIN;
    else                     return r[SW-1:0];
  endfunction

  function automatic logic signed [SW-1:0] neg_sat(input logic signed [SW-1:0] x);
    return (x == S_MIN) ? S_MAX : -x;
  endfunction
endpackage

// File: rtl/vol_tick_gen.sv
module vol_tick_gen #(
  parameter int RAMP_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic tick
);
  localparam int DW = (RAMP_DIV > 1) ? $clog2(RAMP_DIV) : 1;
  logic [DW-1:0] cnt_q;

  assign tick = strobe && (cnt_q == DW'(RAMP_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else if (strobe) cnt_q <= cnt_q + DW'(1);
  end
endmodule

// File: rtl/vol_chan_ctrl.sv
module vol_chan_ctrl
  import vol_seq_pkg::*;
#(
  parameter int TIMEOUT = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strobe,
  input  logic signed [SW-1:0] sample,
  input  logic [CW-1:0]        target,
  input  logic [1:0]           policy,
  input  logic                 tick,
  output logic [CW-1:0]        nxt_code,
  output logic                 zc,
  output logic                 to_hit
);
  localparam int TW = $clog2(TIMEOUT);

  logic [CW-1:0] code_q, tgt_q, step_val;
  logic [TW-1:0] cnt_q;
  logic          prev_neg_q, armed_q, load, want, changed;

  assign load     = (target != tgt_q);
  assign zc       = (sample == '0) || (sample[SW-1] != prev_neg_q);
  assign to_hit   = !load && (cnt_q == TW'(TIMEOUT - 1));
  assign want     = (target != code_q);
  assign step_val = (code_q < target) ? code_q + CW'(1) : code_q - CW'(1);

  always_comb begin
    nxt_code = code_q;
    case (policy_e'(policy))
      POL_NOW:  nxt_code = target;
      POL_ZC:   if (zc || to_hit) nxt_code = target;
      POL_RAMP: if (tick && want) nxt_code = step_val;
      default:  if ((tick || armed_q) && want && (zc || to_hit)) nxt_code = step_val;
    endcase
  end

  assign changed = (nxt_code != code_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q     <= '0;
      tgt_q      <= '0;
      cnt_q      <= '0;
      prev_neg_q <= 1'b0;
      armed_q    <= 1'b0;
    end else if (strobe) begin
      code_q     <= nxt_code;
      tgt_q      <= target;
      prev_neg_q <= sample[SW-1];
      armed_q    <= (policy == POL_BOTH) && (tick || armed_q) && !changed && want;
      if (load || changed)                 cnt_q <= '0;
      else if (cnt_q != TW'(TIMEOUT - 1))  cnt_q <= cnt_q + TW'(1);
    end
  end

  AST_IMMEDIATE_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && policy == POL_NOW |=> code_q == $past(target)) else $error("immediate"); // R2
  AST_ZC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && policy == POL_ZC && !zc && !to_hit |=> $stable(code_q)) else $error("zc gate"); // R3
  AST_RAMP_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && policy[1] |=> (code_q == $past(code_q)) || (code_q == $past(code_q) + CW'(1))
                            || (code_q == $past(code_q) - CW'(1))) else $error("ramp step"); // R5
  AST_BOTH_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && policy == POL_BOTH && !zc && !to_hit |=> $stable(code_q)) else $error("both gate"); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(code_q) && $stable(cnt_q) && $stable(armed_q)) else $error("idle"); // R10
endmodule

// File: rtl/vol_scale_sat.sv
module vol_scale_sat
  import vol_seq_pkg::*;
(
  input  logic signed [SW-1:0] sample,
  input  logic [CW-1:0]        code,
  input  logic                 invert,
  output logic signed [SW-1:0] result
);
  logic signed [SW-1:0] scaled;

  assign scaled = scale_sat(sample, gain_of(code));
  assign result = invert ? neg_sat(scaled) : scaled;
endmodule

// File: rtl/vol_seq.sv
module vol_seq
  import vol_seq_pkg::*;
#(
  parameter int TIMEOUT  = 1024,
  parameter int RAMP_DIV = 8,
  parameter int NCH      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [SW-1:0] in_l,
  input  logic [SW-1:0] in_r,
  input  logic [CW-1:0] atten_l,
  input  logic [CW-1:0] atten_r,
  input  logic [1:0]    mode,
  input  logic          invert,
  output logic          out_valid,
  output logic [SW-1:0] out_l,
  output logic [SW-1:0] out_r
);
  logic                 tick;
  logic [1:0]           policy_q;
  logic signed [SW-1:0] samp   [NCH];
  logic [CW-1:0]        tgt    [NCH];
  logic [CW-1:0]        code_n [NCH];
  logic signed [SW-1:0] res    [NCH];
  logic [NCH-1:0]       zc_w, to_w;

  assign samp[0] = in_l;
  assign samp[1] = in_r;
  assign tgt[0]  = atten_l;
  assign tgt[1]  = atten_r;

  always_ff @(posedge clk) begin
    if (!rst_n)        policy_q <= POL_BOTH;
    else if (in_valid) policy_q <= mode;
  end

  vol_tick_gen #(.RAMP_DIV(RAMP_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .strobe(in_valid), .tick(tick)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    vol_chan_ctrl #(.TIMEOUT(TIMEOUT)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .strobe(in_valid), .sample(samp[ch]),
      .target(tgt[ch]), .policy(policy_q), .tick(tick),
      .nxt_code(code_n[ch]), .zc(zc_w[ch]), .to_hit(to_w[ch])
    );
    vol_scale_sat u_scale (
      .sample(samp[ch]), .code(code_n[ch]), .invert(invert), .result(res[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_l     <= '0;
      out_r     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_l <= res[0];
        out_r <= res[1];
      end
    end
  end

  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid) else $error("out_valid"); // R1
  AST_NO_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_l) && $stable(out_r)) else $error("idle out"); // R10
  AST_INV_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && invert |=> out_l != S_MIN && out_r != S_MIN) else $error("wrap"); // R9
  AST_POLICY_RESET: assert property (@(posedge clk)
    !rst_n |=> policy_q == POL_BOTH) else $error("policy reset"); // R8
endmodule

// File: tb/vol_seq_tb.sv
`timescale 1ns/1ps
module vol_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] in_l = '0, in_r = '0;
  logic [5:0]  atten_l = '0, atten_r = '0;
  logic [1:0]  mode = '0;
  logic        invert = 1'b0;
  logic        out_valid;
  logic [23:0] out_l, out_r;

  int checks = 0, failures = 0;
  bit done = 0;
  string tag = "R10";

  // model state
  int m_cur[2], m_tq[2], m_prev[2], m_cnt[2];
  bit m_arm[2];
  int m_tick, m_mode;
  bit exp_valid;
  int exp_o[2];

  always #4 clk = ~clk;

  vol_seq u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_l(in_l), .in_r(in_r),
    .atten_l(atten_l), .atten_r(atten_r), .mode(mode), .invert(invert),
    .out_valid(out_valid), .out_l(out_l), .out_r(out_r)
  );

  function automatic int gain_ref(int code);
    real g;
    g = 65536.0 * (2.0 ** (-(code % 8) / 8.0));
    return $rtoi(g + 0.5) >> (code / 8);
  endfunction

  function automatic int scale_ref(int s, int g);
    longint p;
    p = (longint'(s) * longint'(g) + 64'sd32768) >>> 16;
    if (p > 8388607) p = 8388607;
    if (p < -8388608) p = -8388608;
    return int'(p);
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_cur[c] = 0; m_tq[c] = 0; m_prev[c] = 0; m_cnt[c] = 0; m_arm[c] = 0;
    end
    m_tick = 0; m_mode = 3; exp_valid = 0; exp_o[0] = 0; exp_o[1] = 0;
  endtask

  task automatic check_one(string what, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic compare();
    check_one("out_valid", int'(out_valid), int'(exp_valid));
    if (exp_valid) begin
      check_one("out_l", int'($signed(out_l)), exp_o[0]);
      check_one("out_r", int'($signed(out_r)), exp_o[1]);
    end
  endtask

  task automatic model_step(bit v, int l, int r, int al, int ar, int md, bit inv);
    bit tick_now;
    exp_valid = v;
    if (!v) return;
    tick_now = (m_tick == 7);
    m_tick = (m_tick + 1) % 8;
    for (int c = 0; c < 2; c++) begin
      int s, t, nw, stp, o;
      bit zc, load, hit, want, chg;
      s = (c == 0) ? l : r;
      t = (c == 0) ? al : ar;
      zc = (s == 0) || ((s < 0) != (m_prev[c] < 0));
      load = (t != m_tq[c]);
      hit = !load && (m_cnt[c] == 1023);
      want = (m_cur[c] != t);
      stp = (m_cur[c] < t) ? m_cur[c] + 1 : m_cur[c] - 1;
      nw = m_cur[c];
      if (m_mode == 0) nw = t;
      else if (m_mode == 1) begin if (zc || hit) nw = t; end
      else if (m_mode == 2) begin if (tick_now && want) nw = stp; end
      else begin if ((tick_now || m_arm[c]) && want && (zc || hit)) nw = stp; end
      chg = (nw != m_cur[c]);
      m_arm[c] = (m_mode == 3) && (tick_now || m_arm[c]) && !chg && want;
      if (load || chg) m_cnt[c] = 0;
      else if (m_cnt[c] < 1023) m_cnt[c]++;
      m_tq[c] = t; m_prev[c] = s; m_cur[c] = nw;
      o = scale_ref(s, gain_ref(nw));
      if (inv) o = (o == -8388608) ? 8388607 : -o;
      exp_o[c] = o;
    end
    m_mode = md;
  endtask

  task automatic drive(bit v, int l, int r, int al, int ar, int md, bit inv);
    @(negedge clk);
    compare();
    in_valid = v; in_l = l[23:0]; in_r = r[23:0];
    atten_l = al[5:0]; atten_r = ar[5:0]; mode = md[1:0]; invert = inv;
    model_step(v, l, r, al, ar, md, inv);
  endtask

  function automatic int pat(int i, int salt);
    longint x;
    x = (longint'(i) * 1103515245 + longint'(salt) * 12345 + 777) % 16777216;
    return int'(x) - 8388608;
  endfunction

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    tag = "R10";  // reset state
    check_one("reset out_valid", int'(out_valid), 0);
    check_one("reset out_l", int'($signed(out_l)), 0);
    check_one("reset out_r", int'($signed(out_r)), 0);
    rst_n = 1'b1;

    // R8: first strobe runs under policy 11 although 00 is presented
    tag = "R8";
    for (int i = 0; i < 4; i++) drive(1, 1000, 2000, 8, 8, 0, 0);

    // R2: immediate policy, varied codes and samples
    tag = "R2";
    for (int i = 0; i < 48; i++) drive(1, pat(i, 1), pat(i, 2), i % 64, (63 - i) % 64, 0, 0);

    // R1: full-scale samples across codes
    tag = "R1";
    for (int i = 0; i < 16; i++) drive(1, 8388607, -8388608, i * 4 % 64, i * 3 % 64, 0, 0);
    drive(0, 5, 5, 1, 1, 0, 0);

    // R3 and R7: zero-cross policy, left flips sign, right does not
    tag = "R3";
    drive(1, 100, 100, 0, 0, 1, 0);
    for (int i = 0; i < 30; i++)
      drive(1, ((i / 5) % 2 == 0) ? 4000 + i : -4000 - i, 3000 + i, 20, 20, 1, 0);
    tag = "R7";
    for (int i = 0; i < 12; i++) drive(1, (i % 2) ? 500 : -500, 3000, 20, 20, 1, 0);

    // R4: timeout with no zero crossing, idle gaps in between
    tag = "R4";
    for (int i = 0; i < 1040; i++) begin
      drive(1, 7000, 6000, 40, 33, 1, 0);
      if (i % 100 == 0) drive(0, -9, -9, 5, 5, 0, 0);
    end

    // R5: ramp policy, both directions, with gaps
    tag = "R5";
    drive(1, 100, 100, 40, 33, 2, 0);
    for (int i = 0; i < 260; i++) begin
      drive(1, pat(i, 5) / 4, 1234, 12, 50, 2, 0);
      if (i % 7 == 0) drive(0, 0, 0, 0, 0, 0, 1);
    end

    // R6: ramp on zero crossings, left flips every 3 strobes, right waits for timeout
    tag = "R6";
    drive(1, 100, 100, 12, 50, 3, 0);
    for (int i = 0; i < 1200; i++)
      drive(1, ((i / 3) % 2 == 0) ? 800 : -800, 900, 30, 40, 3, 0);

    // R9: inversion including the most negative sample
    tag = "R9";
    drive(1, 5, 5, 0, 0, 0, 1);
    drive(1, -8388608, 8388607, 0, 0, 0, 1);
    drive(1, 0, -5, 0, 0, 0, 1);
    drive(1, -8388608, -8388608, 0, 9, 0, 1);
    drive(1, 123457, -765431, 17, 3, 0, 1);

    // R10: idle cycles with changing inputs, then strobes
    tag = "R10";
    for (int i = 0; i < 10; i++) drive(0, pat(i, 9), pat(i, 8), i, 63 - i, i % 4, i % 2);
    for (int i = 0; i < 6; i++) drive(1, 2222, -3333, 17, 3, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule